// File: doc/BRIEF.md
# Byte-Lane Write Control and Data Path

This block sits between the address unit and the storage of a synchronous SRAM word of two 9-bit lanes, each lane eight data bits plus one parity bit. In every cycle it decides, from an active-low global write, an active-low byte-write enable and one active-low select per lane, whether the cycle writes and which lanes it writes. The access is captured into an input register on the rising clock edge and is applied to a small internal array at the following edge. Read data comes from that array at the address captured at the last edge.

Instead of a bidirectional pad, the block exposes separate incoming data, outgoing data and a drive-enable output. The enable follows an asynchronous active-low output-enable pin. It is also dropped automatically for any captured write, for idle cycles and while the sleep input is high. Sleep makes the block ignore new accesses and keeps the stored contents.

Top module: `lanewr_core`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `dq_oe_o` is 0 and `dq_o`/`dp_o` are all zero.
- R2: When `access_i` is high and `gw_n_i` is low at a rising edge, all lanes are written at `addr_i`, whatever `bwe_n_i` and `bsel_n_i` are.
- R3: When `gw_n_i` is high and `bwe_n_i` is low, lane l is written if and only if `bsel_n_i[l]` is low. Lane 0 is `dq_i[7:0]` plus `dp_i[0]`; lane 1 is `dq_i[15:8]` plus `dp_i[1]`.
- R4: An access with `gw_n_i` high and either `bwe_n_i` high or every `bsel_n_i` bit high is a read and changes no stored bit.
- R5: After a read is captured at an edge, until the next edge `dq_o`/`dp_o` show the word stored at the captured address, and `dq_oe_o` is high while `oe_n_i` and `sleep_i` are low. A write captured at the previous edge is already visible to that read.
- R6: `dq_oe_o` is never high while `oe_n_i` is high, and it responds to `oe_n_i` within the same cycle.
- R7: In the cycle after a write is captured, `dq_oe_o` is 0 even with `oe_n_i` low.
- R8: An edge with `access_i` low captures nothing: no lane is written and `dq_oe_o` is 0 in the following cycle.
- R9: While `sleep_i` is high, new accesses are ignored, stored data is kept and `dq_oe_o` is 0. A write captured at the edge before sleep rose is still completed.
- R10: Whenever `dq_oe_o` is 0, `dq_o` and `dp_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | High: ignore accesses, keep contents, outputs off |
| access_i | input | 1 | Address unit marks this cycle as an access |
| addr_i | input | AW (4) | Word address from the address unit |
| gw_n_i | input | 1 | Global write, active low, writes all lanes |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bsel_n_i | input | LANES (2) | Per-lane select, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 16 | Incoming data bits |
| dp_i | input | 2 | Incoming parity bits, one per lane |
| dq_o | output | 16 | Outgoing data bits |
| dp_o | output | 2 | Outgoing parity bits |
| dq_oe_o | output | 1 | Drive enable for the data and parity bus |

## Verification
The commit of a write captured at one edge and the read of that same address captured at the next edge fall in the same cycle. The array update and the new read address both take effect at that edge. The bench provokes this with back-to-back write/read pairs to one address, using full writes and single-lane writes. It judges the read word against a behavioural memory that has already applied the previous write. Sleep rising while a write is pending is the second overlap, and it is checked by reading the address back after wake-up.

// File: rtl/lanewr_pkg.sv
package lanewr_pkg;

   // Kind of access held in the input register
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

endpackage

// File: rtl/lanewr_qualify.sv
// Turns the write strobes into one lane mask and classifies the cycle.
module lanewr_qualify
   import lanewr_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             access_i,
   input  logic             sleep_i,
   input  logic             gw_n_i,
   input  logic             bwe_n_i,
   input  logic [LANES-1:0] bsel_n_i,
   output logic [LANES-1:0] lane_we_o,
   output op_e              op_o
);

   logic             take;
   logic [LANES-1:0] raw_we;

   assign take = access_i & ~sleep_i;

   // global write forces every lane; otherwise each select needs the enable
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign raw_we[l] = ~gw_n_i | (~bwe_n_i & ~bsel_n_i[l]);
   end

   assign lane_we_o = take ? raw_we : '0;

   always_comb begin
      if (!take)          op_o = OP_IDLE;
      else if (|raw_we)   op_o = OP_WRITE;
      else                op_o = OP_READ;
   end

endmodule

// File: rtl/lanewr_inreg.sv
// Input register: captures the qualified access on the rising edge.
module lanewr_inreg
   import lanewr_pkg::*;
#(
   parameter int LANES = 2,
   parameter int LW    = 9,
   parameter int AW    = 4,
   localparam int WW   = LANES * LW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  op_e              op_i,
   input  logic [LANES-1:0] mask_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [WW-1:0]    word_i,
   output op_e              op_q,
   output logic [LANES-1:0] mask_q,
   output logic [AW-1:0]    addr_q,
   output logic [WW-1:0]    word_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         mask_q <= '0;
      end else begin
         op_q   <= op_i;
         mask_q <= mask_i;
      end
   end

   // payload loads only for real accesses; no reset needed
   always_ff @(posedge clk) begin
      if (op_i != OP_IDLE) begin
         addr_q <= addr_i;
         word_q <= word_i;
      end
   end

endmodule

// File: rtl/lanewr_array.sv
// Lane-split storage: one narrow memory per lane, asynchronous read.
module lanewr_array #(
   parameter int LANES = 2,
   parameter int LW    = 9,
   parameter int DEPTH = 16,
   parameter int AW    = 4,
   localparam int WW   = LANES * LW
) (
   input  logic             clk,
   input  logic             we_i,
   input  logic [LANES-1:0] lane_en_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [WW-1:0]    wword_i,
   output logic [WW-1:0]    rword_o
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LW-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we_i && lane_en_i[l]) begin
            store[addr_i] <= wword_i[l*LW +: LW];
         end
      end

      assign rword_o[l*LW +: LW] = store[addr_i];
   end

endmodule

// File: rtl/lanewr_outctl.sv
// Drive-enable and output gating for the data bus.
module lanewr_outctl
   import lanewr_pkg::*;
#(
   parameter int LANES         = 2,
   parameter int LW            = 9,
   parameter bit ZERO_WHEN_OFF = 1'b1,
   localparam int WW           = LANES * LW
) (
   input  op_e           op_q,
   input  logic          oe_n_i,
   input  logic          sleep_i,
   input  logic [WW-1:0] rword_i,
   output logic [WW-1:0] word_o,
   output logic          drive_o
);

   // any write or idle stage turns the bus off, whatever the pin says
   assign drive_o = (op_q == OP_READ) & ~oe_n_i & ~sleep_i;

   if (ZERO_WHEN_OFF) begin : g_zero
      assign word_o = drive_o ? rword_i : '0;
   end else begin : g_pass
      assign word_o = rword_i;
   end

endmodule

// File: rtl/lanewr_core.sv
// Byte-lane write control and data path, top level.
module lanewr_core
   import lanewr_pkg::*;
#(
   parameter int LANES         = 2,
   parameter int LANE_DATA     = 8,
   parameter int LANE_PAR      = 1,
   parameter int DEPTH         = 16,
   parameter bit ZERO_WHEN_OFF = 1'b1,
   localparam int AW  = $clog2(DEPTH),
   localparam int LW  = LANE_DATA + LANE_PAR,
   localparam int DQW = LANES * LANE_DATA,
   localparam int DPW = LANES * LANE_PAR,
   localparam int WW  = LANES * LW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_i,
   input  logic             access_i,
   input  logic [AW-1:0]    addr_i,
   input  logic             gw_n_i,
   input  logic             bwe_n_i,
   input  logic [LANES-1:0] bsel_n_i,
   input  logic             oe_n_i,
   input  logic [DQW-1:0]   dq_i,
   input  logic [DPW-1:0]   dp_i,
   output logic [DQW-1:0]   dq_o,
   output logic [DPW-1:0]   dp_o,
   output logic             dq_oe_o
);

   // elaboration-time parameter checks
   if (LANES < 1) begin : g_bad_lanes
      $error("lanewr_core: LANES must be at least 1");
   end
   if (LANE_DATA < 1 || LANE_PAR < 0) begin : g_bad_lane_w
      $error("lanewr_core: lane widths out of range");
   end
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("lanewr_core: DEPTH must be a power of two >= 2");
   end

   // pack pins into lane-ordered words: {parity, data} per lane
   logic [WW-1:0] in_word, st_word, rd_word, out_word;

   for (genvar l = 0; l < LANES; l++) begin : g_pack
      assign in_word[l*LW +: LANE_DATA] = dq_i[l*LANE_DATA +: LANE_DATA];
      assign dq_o[l*LANE_DATA +: LANE_DATA] = out_word[l*LW +: LANE_DATA];
      if (LANE_PAR > 0) begin : g_par
         assign in_word[l*LW+LANE_DATA +: LANE_PAR] = dp_i[l*LANE_PAR +: LANE_PAR];
         assign dp_o[l*LANE_PAR +: LANE_PAR] = out_word[l*LW+LANE_DATA +: LANE_PAR];
      end
   end

   op_e              cyc_op, st_op;
   logic [LANES-1:0] cyc_mask, st_mask;
   logic [AW-1:0]    st_addr;

   lanewr_qualify #(.LANES(LANES)) qual_i (
      .access_i (access_i),
      .sleep_i  (sleep_i),
      .gw_n_i   (gw_n_i),
      .bwe_n_i  (bwe_n_i),
      .bsel_n_i (bsel_n_i),
      .lane_we_o(cyc_mask),
      .op_o     (cyc_op)
   );

   lanewr_inreg #(.LANES(LANES), .LW(LW), .AW(AW)) inreg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .op_i  (cyc_op),
      .mask_i(cyc_mask),
      .addr_i(addr_i),
      .word_i(in_word),
      .op_q  (st_op),
      .mask_q(st_mask),
      .addr_q(st_addr),
      .word_q(st_word)
   );

   // a captured write lands in the array at the following edge
   lanewr_array #(.LANES(LANES), .LW(LW), .DEPTH(DEPTH), .AW(AW)) array_i (
      .clk      (clk),
      .we_i     (st_op == OP_WRITE),
      .lane_en_i(st_mask),
      .addr_i   (st_addr),
      .wword_i  (st_word),
      .rword_o  (rd_word)
   );

   lanewr_outctl #(.LANES(LANES), .LW(LW), .ZERO_WHEN_OFF(ZERO_WHEN_OFF)) outctl_i (
      .op_q   (st_op),
      .oe_n_i (oe_n_i),
      .sleep_i(sleep_i),
      .rword_i(rd_word),
      .word_o (out_word),
      .drive_o(dq_oe_o)
   );

endmodule

// File: rtl/lanewr_core_chk.sv
// Temporal checks on the port behaviour of lanewr_core.
module lanewr_core_chk #(
   parameter int LANES = 2,
   parameter int DQW   = 16,
   parameter int DPW   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep_i,
   input logic             access_i,
   input logic             gw_n_i,
   input logic             bwe_n_i,
   input logic [LANES-1:0] bsel_n_i,
   input logic             oe_n_i,
   input logic [DQW-1:0]   dq_o,
   input logic [DPW-1:0]   dp_o,
   input logic             dq_oe_o
);

   // R6
   oe_pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe_o |-> !oe_n_i);

   // R9
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> !dq_oe_o);

   // R10
   off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe_o |-> (dq_o == '0 && dp_o == '0));

   // R7
   write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(access_i && !sleep_i &&
         (!gw_n_i || (!bwe_n_i && !(&bsel_n_i))))) |-> !dq_oe_o);

   // R8
   idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!access_i)) |-> !dq_oe_o);

   // R5
   read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(access_i && !sleep_i && gw_n_i &&
         (bwe_n_i || (&bsel_n_i))) && !oe_n_i && !sleep_i) |-> dq_oe_o);

endmodule

bind lanewr_core lanewr_core_chk #(.LANES(LANES), .DQW(DQW), .DPW(DPW)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .sleep_i (sleep_i),
   .access_i(access_i),
   .gw_n_i  (gw_n_i),
   .bwe_n_i (bwe_n_i),
   .bsel_n_i(bsel_n_i),
   .oe_n_i  (oe_n_i),
   .dq_o    (dq_o),
   .dp_o    (dp_o),
   .dq_oe_o (dq_oe_o)
);

// File: tb/lanewr_core_tb_top.sv
`timescale 1ns/1ps
module lanewr_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep_i = 1'b0;
   logic        access_i = 1'b0;
   logic [3:0]  addr_i = '0;
   logic        gw_n_i = 1'b1;
   logic        bwe_n_i = 1'b1;
   logic [1:0]  bsel_n_i = 2'b11;
   logic        oe_n_i = 1'b1;
   logic [15:0] dq_i = '0;
   logic [1:0]  dp_i = '0;
   logic [15:0] dq_o;
   logic [1:0]  dp_o;
   logic        dq_oe_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   lanewr_core dut_i (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .access_i(access_i),
      .addr_i(addr_i), .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i), .bsel_n_i(bsel_n_i),
      .oe_n_i(oe_n_i), .dq_i(dq_i), .dp_i(dp_i), .dq_o(dq_o), .dp_o(dp_o),
      .dq_oe_o(dq_oe_o)
   );

   // behavioural reference: memory plus one captured access
   logic [15:0] m_d [16];
   logic [1:0]  m_p [16];
   int          s_kind = 0;      // 0 idle, 1 read, 2 write
   logic [3:0]  s_addr = '0;
   logic [1:0]  s_mask = '0;
   logic [15:0] s_d = '0;
   logic [1:0]  s_p = '0;

   task automatic check(input string tag);
      logic        e_oe;
      logic [15:0] e_d;
      logic [1:0]  e_p;
      e_oe = !oe_n_i && !sleep_i && (s_kind == 1);
      e_d  = e_oe ? m_d[s_addr] : 16'h0;
      e_p  = e_oe ? m_p[s_addr] : 2'h0;
      total++;
      if (dq_oe_o !== e_oe || dq_o !== e_d || dp_o !== e_p) begin
         bad++;
         $display("FAIL %s: got oe=%b dq=%h dp=%b, expected oe=%b dq=%h dp=%b",
                  tag, dq_oe_o, dq_o, dp_o, e_oe, e_d, e_p);
      end
   endtask

   task automatic model_edge();
      logic [1:0] mk;
      if (s_kind == 2) begin
         for (int l = 0; l < 2; l++) begin
            if (s_mask[l]) begin
               m_d[s_addr][l*8 +: 8] = s_d[l*8 +: 8];
               m_p[s_addr][l]        = s_p[l];
            end
         end
      end
      if (!gw_n_i)       mk = 2'b11;
      else if (!bwe_n_i) mk = ~bsel_n_i;
      else               mk = 2'b00;
      if (!access_i || sleep_i) s_kind = 0;
      else begin
         s_kind = (mk != 0) ? 2 : 1;
         s_mask = mk;
         s_addr = addr_i;
         s_d    = dq_i;
         s_p    = dp_i;
      end
   endtask

   // one clock: drive at falling edge, compare, then advance the model
   task automatic cyc(input string tag, input logic acc, input logic [3:0] a,
                      input logic gw, input logic bwe, input logic [1:0] bs,
                      input logic oe, input logic slp,
                      input logic [15:0] d, input logic [1:0] p);
      @(negedge clk);
      access_i = acc; addr_i = a; gw_n_i = gw; bwe_n_i = bwe; bsel_n_i = bs;
      oe_n_i = oe; sleep_i = slp; dq_i = d; dp_i = p;
      #1;
      check(tag);
      @(posedge clk);
      model_edge();
   endtask

   task automatic rd(input string tag, input logic [3:0] a, input logic oe);
      cyc(tag, 1'b1, a, 1'b1, 1'b1, 2'b11, oe, 1'b0, 16'hDEAD, 2'b11);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      oe_n_i = 1'b0;
      check("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      cyc("R1 after release", 1'b0, 4'd0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 16'h0, 2'b0);

      // R2: global write fills every address, byte strobes scrambled
      for (int i = 0; i < 16; i++) begin
         cyc("R2/R7 global write", 1'b1, 4'(i), 1'b0, 1'(i % 2), 2'(i % 4), 1'b0, 1'b0,
             16'(16'h1357 * (i + 1)), 2'(i));
      end
      for (int i = 0; i < 16; i++) rd("R2/R5 read back", 4'(i), 1'b0);
      rd("R5 last read", 4'd0, 1'b0);

      // R3: single-lane writes, each followed at once by a read of the same word
      cyc("R3 lane0 write", 1'b1, 4'd3, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 16'hA55A, 2'b01);
      rd("R3/R5 lane0 read after write", 4'd3, 1'b0);
      cyc("R3 lane1 write", 1'b1, 4'd4, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 16'h3CC3, 2'b10);
      rd("R3/R5 lane1 read after write", 4'd4, 1'b0);
      cyc("R3 both lanes", 1'b1, 4'd5, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 16'hF00F, 2'b11);
      rd("R3/R5 both read after write", 4'd5, 1'b0);
      cyc("R2 overrides bwe high", 1'b1, 4'd6, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 16'h6666, 2'b10);
      rd("R2/R5 read after global", 4'd6, 1'b0);

      // R4: non-writing strobe combinations leave the word intact
      cyc("R4 bwe high", 1'b1, 4'd7, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 16'hBAD1, 2'b11);
      cyc("R4 no select", 1'b1, 4'd7, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 16'hBAD2, 2'b11);
      rd("R4 word kept", 4'd7, 1'b0);
      rd("R4 word kept again", 4'd7, 1'b0);

      // R6: output enable pin, same-cycle response
      rd("R6 pin high", 4'd8, 1'b1);
      rd("R6 pin low", 4'd8, 1'b0);
      cyc("R6 pin toggles mid read", 1'b1, 4'd9, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 16'h0, 2'b0);

      // R8: no access, strobes active, nothing written
      cyc("R8 idle with write strobes", 1'b0, 4'd10, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 16'hEEEE, 2'b11);
      cyc("R8 idle output off", 1'b0, 4'd10, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 16'h0, 2'b0);
      rd("R8 word kept", 4'd10, 1'b0);

      // R9: write pending when sleep rises, then writes during sleep
      cyc("R9 write before sleep", 1'b1, 4'd11, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 16'h1111, 2'b01);
      cyc("R9 sleep with write", 1'b1, 4'd11, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 16'h2222, 2'b10);
      cyc("R9 sleep read", 1'b1, 4'd12, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 16'h0, 2'b0);
      cyc("R9 sleep write other", 1'b1, 4'd12, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 16'h3333, 2'b11);
      rd("R9 wake read pending", 4'd11, 1'b0);
      rd("R9 wake read kept", 4'd12, 1'b0);
      rd("R9/R10 sleep drops bus", 4'd12, 1'b0);
      cyc("R9 sleep drops current read", 1'b0, 4'd0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 16'h0, 2'b0);

      // R7: write then write, bus must stay off with pin low
      cyc("R7 write", 1'b1, 4'd13, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 16'h7777, 2'b00);
      cyc("R7 write off", 1'b1, 4'd14, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 16'h8888, 2'b01);
      rd("R7 write off again", 4'd14, 1'b0);
      rd("R5 final", 4'd13, 1'b0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule